// File: doc/BRIEF.md
# Stereo PWM Audio DAC Core

This block turns 16-bit PCM samples into one pulse-width-modulated bit per channel (left and right), for an external low-pass filter to smooth into an analog voltage. Software or a DMA engine writes samples and a configuration word through a small register bus. A single-entry pending register takes each sample and hands it to the modulators at a period or repeat boundary. A pulse that has already started is never cut short.

The configuration word sets the run flag, an 8-bit (256-count) or 10-bit (1024-count) period, the pulse placement inside the period, how many whole periods each sample stays on the output, an optional MSB flip that turns two's-complement samples into offset binary, and a left shift of 0 to 7 applied before the top bits are taken as the duty value. The bus never stalls. A new sample written before the pending one has been consumed replaces it, so `bus_ready` is always high and a writer needs no flow control beyond pacing its writes to the sample rate. For example, a 12.288 MHz clock with an 8-bit period and one period per sample gives a 48 kHz rate (256 clocks per sample).

Top module: `pwmdac_stereo`

## Requirements
- R1: After reset the configuration word is zero (modulator stopped), no sample is pending and both PWM outputs are low.
- R2: While configuration bit 0 (run) is 0 the period counter stays at 0, and one clock after run is seen low both outputs are low. Setting run starts a period at count 0.
- R3: With bit 1 at 0 the period is 256 clocks and the duty D is bits [15:8] of the processed sample. Each output is registered: the value seen in a cycle is the decision for the count of the previous cycle.
- R4: With bit 1 at 1 the period is 1024 clocks and D is bits [15:6] of the processed sample.
- R5: Bits [3:2] place the D high clocks of each period of length P: 0 puts them at counts 0..D-1, 1 puts them at counts P-D..P-1, and 2 or 3 centres them, starting at count floor((P-D)/2).
- R6: Bits [12:4] hold N-1, and a sample stays on the outputs for N whole periods (1 to 512) before the pending sample is taken. While stopped, a pending sample is taken at once.
- R7: When bit 13 is set and a sample is pending, the sample is taken at the end of the current period, without waiting for the N-period count.
- R8: When bit 14 is set, bit 15 of each sample is inverted before any other processing.
- R9: Bits [17:15] give a left shift of 0 to 7 that is applied, dropping overflow bits, to the 16-bit sample after the MSB flip and before the duty bits are taken.
- R10: A write to offset 0x0 with `bus_mono` low loads the left sample from bits [15:0] and the right sample from bits [31:16]. With `bus_mono` high, bits [15:0] feed both channels.
- R11: A second write that arrives before the pending sample is taken replaces it. If nothing is pending at a boundary, the current sample keeps playing.
- R12: Writes to offsets other than 0x0 (sample) and 0x4 (configuration) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one PWM count per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Write strobe for the register bus |
| bus_ready | output | 1 | Always high; writes are never stalled |
| bus_addr | input | 4 | Byte offset of the write |
| bus_wdata | input | 32 | Write data |
| bus_mono | input | 1 | Sample write carries one 16-bit sample for both channels |
| pwm_left | output | 1 | Left channel PWM bit |
| pwm_right | output | 1 | Right channel PWM bit |

## Verification
The embedded assertions check, on every cycle, that a stopped modulator keeps its counter at zero and its outputs low, that the repeat counter never runs past its limit, that a left-aligned non-zero duty raises the output at count zero, that the playing sample changes only on a take strobe, that a sample write always leaves a sample pending, and that stray offsets disturb no register. Only the bench's scenarios can show the whole-period pulse shapes for each alignment and resolution, the sample processing (flip, shift, truncation, mono copy), and the order in which samples reach the outputs under repeat counts, early swap and overwrite. The bench compares every output bit of a period against a pattern computed from the requirements.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;

  localparam int SAMPLE_W = 16;
  localparam int LO_RES   = 8;
  localparam int HI_RES   = 10;
  localparam int CNT_W    = HI_RES;
  localparam int REP_W    = 9;
  localparam int SHIFT_W  = 3;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;
  localparam int NUM_CH   = 2;

  localparam logic [ADDR_W-1:0] OFS_SAMPLE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CONFIG = 4'h4;

  typedef enum logic [1:0] {
    PLACE_HEAD   = 2'd0,
    PLACE_TAIL   = 2'd1,
    PLACE_MID    = 2'd2,
    PLACE_MID_B  = 2'd3
  } place_e;

  // Field positions are software-visible: packed MSB first.
  typedef struct packed {
    logic [SHIFT_W-1:0] pre_shift;  // [17:15]
    logic               msb_flip;   // [14]
    logic               early_swap; // [13]
    logic [REP_W-1:0]   hold_m1;    // [12:4]
    place_e             place;      // [3:2]
    logic               wide;       // [1]
    logic               run;        // [0]
  } cfg_t;

  localparam int CFG_BITS = $bits(cfg_t);

endpackage

// File: rtl/pwmdac_regs.sv
module pwmdac_regs
  import pwmdac_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_valid,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_mono,
  input  logic                           take_i,
  output cfg_t                           cfg_o,
  output logic                           pend_vld_o,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0] pend_o
);

  cfg_t                            cfg_q;
  logic                            pend_vld_q;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] pend_q;
  logic                            wr_sample;
  logic                            wr_cfg;

  assign wr_sample = bus_valid && (bus_addr == OFS_SAMPLE);
  assign wr_cfg    = bus_valid && (bus_addr == OFS_CONFIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= cfg_t'(bus_wdata[CFG_BITS-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (wr_sample) begin
        pend_q[0]  <= bus_wdata[SAMPLE_W-1:0];
        pend_q[1]  <= bus_mono ? bus_wdata[SAMPLE_W-1:0]
                               : bus_wdata[2*SAMPLE_W-1:SAMPLE_W];
        pend_vld_q <= 1'b1;
      end else if (take_i) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign cfg_o      = cfg_q;
  assign pend_vld_o = pend_vld_q;
  assign pend_o     = pend_q;

  // R11
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sample |=> pend_vld_q);

  // R12
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !wr_sample && !wr_cfg) |=> ($stable(cfg_q) && $stable(pend_q)));

endmodule

// File: rtl/pwmdac_timebase.sv
module pwmdac_timebase
  import pwmdac_pkg::*;
#(
  parameter int LO = LO_RES,
  parameter int HI = HI_RES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wide_i,
  input  logic [REP_W-1:0] hold_m1_i,
  input  logic             early_swap_i,
  input  logic             pend_vld_i,
  output logic [HI-1:0]    cnt_o,
  output logic             take_o
);

  localparam logic [HI-1:0] LAST_HI = '1;
  localparam logic [HI-1:0] LAST_LO = HI'((1 << LO) - 1);

  logic [HI-1:0]    cnt_q;
  logic [REP_W-1:0] rep_q;
  logic [HI-1:0]    last;
  logic             period_end;
  logic             swap;

  assign last       = wide_i ? LAST_HI : LAST_LO;
  assign period_end = run_i && (cnt_q >= last);
  assign swap       = period_end && ((rep_q >= hold_m1_i) || (early_swap_i && pend_vld_i));
  assign take_o     = !run_i || swap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run_i || period_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= '0;
    end else if (!run_i || swap) begin
      rep_q <= '0;
    end else if (period_end) begin
      rep_q <= rep_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R2
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

  // R6
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (rep_q < hold_m1_i)) |=> (rep_q <= $past(hold_m1_i)));

endmodule

// File: rtl/pwmdac_chan.sv
module pwmdac_chan
  import pwmdac_pkg::*;
#(
  parameter int LO = LO_RES,
  parameter int HI = HI_RES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic                wide_i,
  input  place_e              place_i,
  input  logic                msb_flip_i,
  input  logic [SHIFT_W-1:0]  pre_shift_i,
  input  logic [HI-1:0]       cnt_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                pwm_o
);

  localparam int               XW     = HI + 1;
  localparam logic [XW-1:0]    PER_HI = XW'(1 << HI);
  localparam logic [XW-1:0]    PER_LO = XW'(1 << LO);
  localparam logic [SAMPLE_W-1:0] TOP = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] active_q;
  logic [SAMPLE_W-1:0] flipped;
  logic [SAMPLE_W-1:0] shifted;
  logic [XW-1:0]       duty;
  logic [XW-1:0]       per;
  logic [XW-1:0]       cnt_x;
  logic [XW-1:0]       mid_start;
  logic                hit;
  logic                pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else if (load_i) begin
      active_q <= sample_i;
    end
  end

  always_comb begin
    flipped = msb_flip_i ? (active_q ^ TOP) : active_q;
    shifted = flipped << pre_shift_i;
    if (wide_i) begin
      duty = XW'(shifted[SAMPLE_W-1 -: HI]);
      per  = PER_HI;
    end else begin
      duty = XW'(shifted[SAMPLE_W-1 -: LO]);
      per  = PER_LO;
    end
  end

  always_comb begin
    cnt_x     = XW'(cnt_i);
    mid_start = (per - duty) >> 1;
    unique case (place_i)
      PLACE_HEAD: hit = cnt_x < duty;
      PLACE_TAIL: hit = cnt_x >= (per - duty);
      default:    hit = (cnt_x >= mid_start) && (cnt_x < (mid_start + duty));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= run_i && hit;
    end
  end

  assign pwm_o = pwm_q;

  // R2
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pwm_o);

  // R5
  head_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (place_i == PLACE_HEAD) && (cnt_i == '0) && (duty != '0)) |=> pwm_o);

  // R11
  hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(active_q));

endmodule

// File: rtl/pwmdac_stereo.sv
module pwmdac_stereo
  import pwmdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_mono,
  output logic              pwm_left,
  output logic              pwm_right
);

  cfg_t                            cfg;
  logic                            pend_vld;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] pend;
  logic [CNT_W-1:0]                cnt;
  logic                            take;
  logic                            load;
  logic [NUM_CH-1:0]               pwm;

  assign bus_ready = 1'b1;
  assign load      = take && pend_vld;

  pwmdac_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_mono   (bus_mono),
    .take_i     (take),
    .cfg_o      (cfg),
    .pend_vld_o (pend_vld),
    .pend_o     (pend)
  );

  pwmdac_timebase #(.LO(LO_RES), .HI(HI_RES)) u_time (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (cfg.run),
    .wide_i       (cfg.wide),
    .hold_m1_i    (cfg.hold_m1),
    .early_swap_i (cfg.early_swap),
    .pend_vld_i   (pend_vld),
    .cnt_o        (cnt),
    .take_o       (take)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwmdac_chan #(.LO(LO_RES), .HI(HI_RES)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_i       (cfg.run),
      .wide_i      (cfg.wide),
      .place_i     (cfg.place),
      .msb_flip_i  (cfg.msb_flip),
      .pre_shift_i (cfg.pre_shift),
      .cnt_i       (cnt),
      .load_i      (load),
      .sample_i    (pend[ch]),
      .pwm_o       (pwm[ch])
    );
  end

  assign pwm_left  = pwm[0];
  assign pwm_right = pwm[1];

endmodule

// File: tb/pwmdac_stereo_test.sv
module pwmdac_stereo_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_mono = 1'b0;
  logic        pwm_left;
  logic        pwm_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmdac_stereo uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_mono(bus_mono),
    .pwm_left(pwm_left), .pwm_right(pwm_right)
  );

  function automatic int exp_duty(logic [15:0] raw, bit flip, int sh, bit wide);
    logic [15:0] v;
    v = flip ? (raw ^ 16'h8000) : raw;
    v = v << sh;
    return wide ? int'(v[15:6]) : int'(v[15:8]);
  endfunction

  function automatic bit exp_bit(int d, int per, int pl, int k);
    int s;
    if (pl == 0) return k < d;
    if (pl == 1) return k >= per - d;
    s = (per - d) / 2;
    return (k >= s) && (k < s + d);
  endfunction

  function automatic logic [31:0] mk_cfg(bit run, bit wide, int pl, int hm1,
                                         bit swp, bit flip, int sh);
    return {14'd0, 3'(sh), flip, swp, 9'(hm1), 2'(pl), wide, run};
  endfunction

  task automatic bus_write(logic [3:0] a, logic [31:0] d, bit mono);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_mono = mono;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_mono = 1'b0;
  endtask

  task automatic start(logic [31:0] cfg, logic [31:0] smp, bit mono);
    bus_write(4'h4, cfg & ~32'd1, 1'b0);
    bus_write(4'h0, smp, mono);
    bus_write(4'h4, cfg | 32'd1, 1'b0);
  endtask

  task automatic check_period(int dl, int dr, int per, int pl, string tag);
    int bad_l = -1, bad_r = -1;
    bit al = 0, ar = 0;
    for (int k = 0; k < per; k++) begin
      @(negedge clk);
      if (bad_l < 0 && pwm_left !== exp_bit(dl, per, pl, k)) begin bad_l = k; al = pwm_left; end
      if (bad_r < 0 && pwm_right !== exp_bit(dr, per, pl, k)) begin bad_r = k; ar = pwm_right; end
    end
    checks += 2;
    if (bad_l >= 0) begin
      errors++;
      $display("FAIL %s left count %0d: actual %0b expected %0b (duty %0d)", tag, bad_l, al, ~al, dl);
    end
    if (bad_r >= 0) begin
      errors++;
      $display("FAIL %s right count %0d: actual %0b expected %0b (duty %0d)", tag, bad_r, ar, ~ar, dr);
    end
  endtask

  task automatic check_low(string tag);
    checks++;
    if (pwm_left !== 1'b0 || pwm_right !== 1'b0) begin
      errors++;
      $display("FAIL %s: actual %0b%0b expected 00", tag, pwm_left, pwm_right);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    // R1 reset state
    check_low("R1 during reset");
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_low("R1 after reset");
    end
    checks++;
    if (bus_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 bus_ready: actual %0b expected 1", bus_ready);
    end

    // R3 8-bit head placement
    start(mk_cfg(1, 0, 0, 0, 0, 0, 0), 32'h00FF_8000, 0);
    check_period(128, 0, 256, 0, "R3 head");
    // R5 tail, centre, value 3
    start(mk_cfg(1, 0, 1, 0, 0, 0, 0), 32'hFF00_4B00, 0);
    check_period(75, 255, 256, 1, "R5 tail");
    start(mk_cfg(1, 0, 2, 0, 0, 0, 0), 32'hFF00_4B00, 0);
    check_period(75, 255, 256, 2, "R5 centre");
    start(mk_cfg(1, 0, 3, 0, 0, 0, 0), 32'h0100_4C00, 0);
    check_period(76, 1, 256, 3, "R5 centre alt");
    // R4 10-bit
    start(mk_cfg(1, 1, 2, 0, 0, 0, 0), 32'h1234_FFFF, 0);
    check_period(1023, 72, 1024, 2, "R4 wide");
    // R8 MSB flip
    start(mk_cfg(1, 0, 0, 0, 0, 1, 0), 32'h8000_0000, 0);
    check_period(128, 0, 256, 0, "R8 flip");
    // R9 shift
    start(mk_cfg(1, 0, 0, 0, 0, 0, 3), 32'h0123_1F00, 0);
    check_period(248, 9, 256, 0, "R9 shift");
    // R10 mono
    start(mk_cfg(1, 0, 0, 0, 0, 0, 0), 32'hAAAA_3000, 1);
    check_period(48, 48, 256, 0, "R10 mono");

    // R6 repeat count two periods, R11 hold when nothing pending
    start(mk_cfg(1, 0, 0, 1, 0, 0, 0), 32'h2000_4000, 0);
    fork
      begin
        check_period(64, 32, 256, 0, "R6 period0");
        check_period(64, 32, 256, 0, "R6 period1");
        check_period(96, 16, 256, 0, "R6 period2");
        check_period(96, 16, 256, 0, "R11 hold period3");
      end
      begin
        repeat (20) @(negedge clk);
        bus_write(4'h0, 32'h1000_6000, 0);
      end
    join

    // R7 early swap
    start(mk_cfg(1, 0, 0, 3, 1, 0, 0), 32'h2000_4000, 0);
    fork
      begin
        check_period(64, 32, 256, 0, "R7 period0");
        check_period(96, 16, 256, 0, "R7 period1");
      end
      begin
        repeat (30) @(negedge clk);
        bus_write(4'h0, 32'h1000_6000, 0);
      end
    join

    // R11 overwrite of pending
    start(mk_cfg(1, 0, 1, 0, 0, 0, 0), 32'h2000_4000, 0);
    fork
      begin
        check_period(64, 32, 256, 1, "R11 period0");
        check_period(200, 5, 256, 1, "R11 overwrite");
      end
      begin
        repeat (20) @(negedge clk);
        bus_write(4'h0, 32'h1000_6000, 0);
        repeat (30) @(negedge clk);
        bus_write(4'h0, 32'h0500_C800, 0);
      end
    join

    // R12 stray offsets
    start(mk_cfg(1, 0, 0, 0, 0, 0, 0), 32'h2000_4000, 0);
    fork
      begin
        check_period(64, 32, 256, 0, "R12 period0");
        check_period(64, 32, 256, 0, "R12 period1");
      end
      begin
        repeat (10) @(negedge clk);
        bus_write(4'h8, 32'h0000_0000, 0);
        bus_write(4'hC, 32'hFFFF_FFFF, 0);
        bus_write(4'h2, 32'h0000_0000, 0);
      end
    join

    // R2 stop drops outputs
    start(mk_cfg(1, 0, 0, 0, 0, 0, 0), 32'hFF00_FF00, 0);
    check_period(255, 255, 256, 0, "R2 before stop");
    repeat (40) @(negedge clk);
    bus_write(4'h4, mk_cfg(0, 0, 0, 0, 0, 0, 0), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_low("R2 stopped");
    end

    // Random mix covering R3 R4 R5 R8 R9 R10
    for (int t = 0; t < 16; t++) begin
      logic [15:0] l, r;
      bit wide, flip, mono;
      int pl, sh, per;
      l = 16'($urandom); r = 16'($urandom);
      wide = ($urandom % 4) == 0;
      flip = 1'($urandom);
      mono = ($urandom % 5) == 0;
      pl = $urandom % 4;
      sh = $urandom % 8;
      per = wide ? 1024 : 256;
      if (mono) r = l;
      start(mk_cfg(1, wide, pl, 0, 0, flip, sh), {r, l}, mono);
      check_period(exp_duty(l, flip, sh, wide), exp_duty(r, flip, sh, wide),
                   per, pl, "R5 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule